// File: doc/BRIEF.md
# Configurable Maximal-Length Pseudo-Noise Generator

This block is a shift-register sequence generator with external feedback. It produces a pseudo-noise bit stream on a serial output and presents the whole register as a parallel word. The register length is fixed when the block is built and may be 8, 16 or 32 stages. Each length has its own fixed feedback polynomial, chosen so that the sequence visits every legal state before it repeats. The feedback gate is also fixed at build time, as either exclusive-OR or its complement.

A seed can be loaded at any time. The block rejects the one seed that would freeze the register for the chosen feedback gate: it puts in a legal default state and flags the rejection for one cycle. It also raises a one-cycle pulse each time the register comes back to the seed most recently accepted, so a user can confirm that a full period has elapsed.

Top module: `pn_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes the default seed. The default is 1 (only bit 0 set) with exclusive-OR feedback and the bitwise complement of 1 with complemented feedback. `seedInvalid` and `periodDone` are 0.
- R2: On each edge with `enable` high and `loadSeed` low, every bit i moves to bit i-1. The new feedback bit enters bit WIDTH-1, which is the leftmost stage. `pnBit` always equals bit 0, which is the rightmost stage.
- R3: A polynomial term x^k taps state bit WIDTH-k. The feedback bit is the XOR of the tapped bits, inverted when `USE_XNOR` is 1. For WIDTH 8 the taps are x^8, x^6, x^5 and x^4, so bits 0, 2, 3 and 4.
- R4: For WIDTH 16 the taps are x^16, x^14, x^13 and x^11, so bits 0, 2, 3 and 5. The 8-stage register repeats every 255 steps and the 16-stage register every 65535 steps.
- R5: For WIDTH 32 the taps are x^32, x^22, x^2 and x^1, so bits 0, 10, 30 and 31.
- R6: With `loadSeed` high at an edge and a legal `seedIn`, the state and the stored seed take `seedIn`, whatever `enable` is. No shift happens in that cycle.
- R7: The lock-up seed is all zeros with exclusive-OR feedback and all ones with complemented feedback. When that seed is loaded, the state and the stored seed take the default from R1, and `seedInvalid` is 1 for exactly the following cycle.
- R8: `periodDone` is 1 for the cycle after a shift step whose result equals the stored seed, and 0 otherwise.
- R9: With `enable` low and `loadSeed` low, the state holds and `periodDone` stays 0. Held cycles do not count toward a period.
- R10: Outside reset the state never equals the lock-up value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the register one step |
| loadSeed | input | 1 | Load `seedIn` (overrides `enable`) |
| seedIn | input | WIDTH | Seed value |
| pnBit | output | 1 | Serial pseudo-noise bit (rightmost stage) |
| stateOut | output | WIDTH | Full register contents |
| seedInvalid | output | 1 | One-cycle pulse: lock-up seed replaced by default |
| periodDone | output | 1 | One-cycle pulse: state returned to stored seed |

## Verification
The bench builds four instances side by side: 8 stages with exclusive-OR, 8 stages with complemented feedback, 16 stages and 32 stages. All four see the same inputs, and a behavioural model steps each one using its list of polynomial exponents. A free run after reset separates wrong tap positions and a wrong shift direction. Loads of all-zeros and all-ones each trigger the rejection on one feedback type while the other accepts the seed, which separates the two lock-up rules. A full 65535-step run confirms the period of the 8- and 16-stage registers. In a second run, enable is dropped for a while just before the period would finish, to show that held cycles do not count.

// File: rtl/pn_pkg.sv
package pn_pkg;

  typedef struct packed {
    logic load;
    logic shift;
    logic useDefault;
  } pn_strobe_t;

  // Tap mask: polynomial term x^k maps to state bit (width - k).
  function automatic logic [31:0] tapMask(input int width);
    logic [31:0] m;
    m = '0;
    case (width)
      8:  m = 32'h0000_001D;   // bits 0,2,3,4
      16: m = 32'h0000_002D;   // bits 0,2,3,5
      32: m = 32'hC000_0401;   // bits 0,10,30,31
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pn_datapath.sv
module pn_datapath #(
  parameter int WIDTH    = 8,
  parameter bit USE_XNOR = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  pn_pkg::pn_strobe_t     ctl,
  input  logic [WIDTH-1:0]       seedIn,
  output logic [WIDTH-1:0]       stateQ,
  output logic                   lockSeed,
  output logic                   wrapNext
);
  localparam logic [31:0]      TAP_FULL = pn_pkg::tapMask(WIDTH);
  localparam logic [WIDTH-1:0] TAPS     = TAP_FULL[WIDTH-1:0];
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] DEF_SEED = USE_XNOR ? ~ONE : ONE;
  localparam logic [WIDTH-1:0] LOCK_VAL = USE_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] seedQ;
  logic [WIDTH-1:0] shifted;
  logic             feedback;
  logic             parity;

  assign parity = ^(stateQ & TAPS);

  generate
    if (USE_XNOR) begin : g_xnor
      assign feedback = ~parity;
    end else begin : g_xor
      assign feedback = parity;
    end
  endgenerate

  assign shifted  = {feedback, stateQ[WIDTH-1:1]};
  assign lockSeed = (seedIn == LOCK_VAL);
  assign wrapNext = (shifted == seedQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= DEF_SEED;
      seedQ  <= DEF_SEED;
    end else if (ctl.load) begin
      stateQ <= ctl.useDefault ? DEF_SEED : seedIn;
      seedQ  <= ctl.useDefault ? DEF_SEED : seedIn;
    end else if (ctl.shift) begin
      stateQ <= shifted;
    end
  end

endmodule

// File: rtl/pn_ctrl.sv
module pn_ctrl (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               loadSeed,
  input  logic               lockSeed,
  input  logic               wrapNext,
  output pn_pkg::pn_strobe_t ctl,
  output logic               seedInvalid,
  output logic               periodDone
);
  always_comb begin
    ctl.load       = loadSeed;
    ctl.shift      = enable & ~loadSeed;
    ctl.useDefault = loadSeed & lockSeed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seedInvalid <= 1'b0;
      periodDone  <= 1'b0;
    end else begin
      seedInvalid <= ctl.useDefault;
      periodDone  <= ctl.shift & wrapNext;
    end
  end

endmodule

// File: rtl/pn_gen.sv
module pn_gen #(
  parameter int WIDTH    = 8,
  parameter bit USE_XNOR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             loadSeed,
  input  logic [WIDTH-1:0] seedIn,
  output logic             pnBit,
  output logic [WIDTH-1:0] stateOut,
  output logic             seedInvalid,
  output logic             periodDone
);
  pn_pkg::pn_strobe_t ctl;
  logic lockSeed;
  logic wrapNext;

  pn_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .loadSeed    (loadSeed),
    .lockSeed    (lockSeed),
    .wrapNext    (wrapNext),
    .ctl         (ctl),
    .seedInvalid (seedInvalid),
    .periodDone  (periodDone)
  );

  pn_datapath #(.WIDTH(WIDTH), .USE_XNOR(USE_XNOR)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .seedIn   (seedIn),
    .stateQ   (stateOut),
    .lockSeed (lockSeed),
    .wrapNext (wrapNext)
  );

  assign pnBit = stateOut[0];

endmodule

// File: rtl/pn_gen_chk.sv
module pn_gen_chk #(
  parameter int WIDTH    = 8,
  parameter bit USE_XNOR = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             loadSeed,
  input logic [WIDTH-1:0] seedIn,
  input logic             pnBit,
  input logic [WIDTH-1:0] stateOut,
  input logic             seedInvalid,
  input logic             periodDone
);
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] DEF_SEED = USE_XNOR ? ~ONE : ONE;
  localparam logic [WIDTH-1:0] LOCK_VAL = USE_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (enable && !loadSeed) |=> stateOut[WIDTH-2:0] == $past(stateOut[WIDTH-1:1]));

  p_serial_r2: assert property (@(posedge clk) disable iff (rst)
    (enable && !loadSeed) |=> pnBit == $past(stateOut[1]));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (loadSeed && seedIn != LOCK_VAL) |=> (stateOut == $past(seedIn)) && !seedInvalid);

  p_bad_seed_r7: assert property (@(posedge clk) disable iff (rst)
    (loadSeed && seedIn == LOCK_VAL) |=> (stateOut == DEF_SEED) && seedInvalid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !loadSeed) |=> $stable(stateOut) && !periodDone);

  p_no_lockup_r10: assert property (@(posedge clk) disable iff (rst)
    stateOut != LOCK_VAL);

endmodule

bind pn_gen pn_gen_chk #(.WIDTH(WIDTH), .USE_XNOR(USE_XNOR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .loadSeed    (loadSeed),
  .seedIn      (seedIn),
  .pnBit       (pnBit),
  .stateOut    (stateOut),
  .seedInvalid (seedInvalid),
  .periodDone  (periodDone)
);

// File: tb/pn_gen_tb.sv
module pn_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NINST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic ld = 1'b0;
  logic [31:0] seed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  s8, s8n;
  logic [15:0] s16;
  logic [31:0] s32;
  logic b8, b8n, b16, b32;
  logic inv8, inv8n, inv16, inv32;
  logic pd8, pd8n, pd16, pd32;

  pn_gen #(.WIDTH(8), .USE_XNOR(1'b0)) u_dut (
    .clk(clk), .rst(rst), .enable(en), .loadSeed(ld), .seedIn(seed[7:0]),
    .pnBit(b8), .stateOut(s8), .seedInvalid(inv8), .periodDone(pd8));
  pn_gen #(.WIDTH(8), .USE_XNOR(1'b1)) u_dut8n (
    .clk(clk), .rst(rst), .enable(en), .loadSeed(ld), .seedIn(seed[7:0]),
    .pnBit(b8n), .stateOut(s8n), .seedInvalid(inv8n), .periodDone(pd8n));
  pn_gen #(.WIDTH(16), .USE_XNOR(1'b0)) u_dut16 (
    .clk(clk), .rst(rst), .enable(en), .loadSeed(ld), .seedIn(seed[15:0]),
    .pnBit(b16), .stateOut(s16), .seedInvalid(inv16), .periodDone(pd16));
  pn_gen #(.WIDTH(32), .USE_XNOR(1'b0)) u_dut32 (
    .clk(clk), .rst(rst), .enable(en), .loadSeed(ld), .seedIn(seed),
    .pnBit(b32), .stateOut(s32), .seedInvalid(inv32), .periodDone(pd32));

  logic [31:0] dState [NINST];
  logic        dBit   [NINST];
  logic        dInv   [NINST];
  logic        dPd    [NINST];
  assign dState[0] = {24'b0, s8};  assign dBit[0] = b8;  assign dInv[0] = inv8;  assign dPd[0] = pd8;
  assign dState[1] = {24'b0, s8n}; assign dBit[1] = b8n; assign dInv[1] = inv8n; assign dPd[1] = pd8n;
  assign dState[2] = {16'b0, s16}; assign dBit[2] = b16; assign dInv[2] = inv16; assign dPd[2] = pd16;
  assign dState[3] = s32;          assign dBit[3] = b32; assign dInv[3] = inv32; assign dPd[3] = pd32;

  int widthOf [NINST] = '{8, 8, 16, 32};
  bit xnorOf  [NINST] = '{1'b0, 1'b1, 1'b0, 1'b0};

  logic [31:0] mState [NINST];
  logic [31:0] mSeed  [NINST];
  logic        mInv   [NINST];
  logic        mPd    [NINST];

  int checks = 0;
  int fails = 0;
  string phaseTag = "R1";

  function automatic logic [31:0] widthMask(int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] defaultOf(int w, bit xn);
    return xn ? (widthMask(w) & ~32'd1) : 32'd1;
  endfunction

  function automatic logic [31:0] lockOf(int w, bit xn);
    return xn ? widthMask(w) : 32'd0;
  endfunction

  // Behavioural step from the polynomial exponents (R3, R4, R5).
  function automatic logic [31:0] modelStep(int w, bit xn, logic [31:0] s);
    int e [4];
    logic fb;
    case (w)
      8:  e = '{8, 6, 5, 4};
      16: e = '{16, 14, 13, 11};
      default: e = '{32, 22, 2, 1};
    endcase
    fb = 1'b0;
    for (int i = 0; i < 4; i++) fb = fb ^ s[w - e[i]];
    if (xn) fb = ~fb;
    return (s >> 1) | ({31'b0, fb} << (w - 1));
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < NINST; k++) begin
      int w;
      logic [31:0] sl;
      w = widthOf[k];
      sl = seed & widthMask(w);
      if (rst) begin
        mState[k] = defaultOf(w, xnorOf[k]);
        mSeed[k]  = defaultOf(w, xnorOf[k]);
        mInv[k] = 1'b0; mPd[k] = 1'b0;
      end else if (ld) begin
        mPd[k] = 1'b0;
        if (sl == lockOf(w, xnorOf[k])) begin
          mState[k] = defaultOf(w, xnorOf[k]);
          mSeed[k]  = defaultOf(w, xnorOf[k]);
          mInv[k] = 1'b1;
        end else begin
          mState[k] = sl; mSeed[k] = sl; mInv[k] = 1'b0;
        end
      end else if (en) begin
        mState[k] = modelStep(w, xnorOf[k], mState[k]);
        mPd[k] = (mState[k] == mSeed[k]);
        mInv[k] = 1'b0;
      end else begin
        mPd[k] = 1'b0; mInv[k] = 1'b0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison with the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NINST; k++) begin
        chk({phaseTag, " state"}, dState[k], mState[k]);
        chk({phaseTag, " R2 serial"}, {31'b0, dBit[k]}, {31'b0, mState[k][0]});
        chk({phaseTag, " R7 invalid"}, {31'b0, dInv[k]}, {31'b0, mInv[k]});
        chk({phaseTag, " R8 period"}, {31'b0, dPd[k]}, {31'b0, mPd[k]});
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadValue(logic [31:0] v);
    ld = 1'b1; seed = v;
    tick(1);
    ld = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset values
    chk("R1 reset 8x", {24'b0, s8}, 32'h01);
    chk("R1 reset 8n", {24'b0, s8n}, 32'hFE);
    chk("R1 reset 16", {16'b0, s16}, 32'h0001);
    chk("R1 reset 32", s32, 32'h1);
    chk("R1 flags", {28'b0, inv8, inv8n, pd8, pd16}, 32'h0);

    rst = 1'b0;
    // R2 R3 R5: free run from default
    phaseTag = "R3"; en = 1'b1;
    tick(1);
    chk("R2 first step 8x", {24'b0, s8}, 32'h80);
    chk("R3 first step 8n", {24'b0, s8n}, 32'h7F);
    chk("R5 first step 32", s32, 32'h8000_0000);
    tick(40);

    // R9: hold
    phaseTag = "R9"; en = 1'b0;
    begin
      logic [31:0] held;
      held = s32;
      tick(5);
      chk("R9 hold 32", s32, held);
    end

    // R6: load while enabled, load wins over shift
    phaseTag = "R6"; en = 1'b1;
    loadValue(32'h1234_5A5A);
    chk("R6 load 8x", {24'b0, s8}, 32'h5A);
    chk("R6 load 32", s32, 32'h1234_5A5A);
    tick(10);

    // R7: all-zeros rejected by XOR, accepted by XNOR
    phaseTag = "R7"; en = 1'b0;
    loadValue(32'h0);
    chk("R7 zero seed 8x", {24'b0, s8}, 32'h01);
    chk("R7 zero seed pulse", {31'b0, inv8}, 32'h1);
    chk("R7 zero seed xnor ok", {24'b0, s8n}, 32'h00);
    tick(1);
    chk("R7 pulse one cycle", {31'b0, inv8}, 32'h0);
    loadValue(32'hFFFF_FFFF);
    chk("R7 ones seed 8n", {24'b0, s8n}, 32'hFE);
    chk("R7 ones seed pulse 8n", {31'b0, inv8n}, 32'h1);
    chk("R7 ones seed 32 ok", s32, 32'hFFFF_FFFF);

    // R8 R9: period with a pause just before it completes
    phaseTag = "R8";
    loadValue(32'h0000_005A);
    en = 1'b1; tick(254);
    chk("R8 no early pulse", {31'b0, pd8}, 32'h0);
    en = 1'b0; tick(10);
    chk("R9 frozen no pulse", {31'b0, pd8}, 32'h0);
    en = 1'b1; tick(1);
    chk("R8 pulse at 255", {31'b0, pd8}, 32'h1);
    chk("R8 back at seed", {24'b0, s8}, 32'h5A);
    tick(1);
    chk("R8 pulse ends", {31'b0, pd8}, 32'h0);

    // R4: full 65535-step period of 16 stages
    phaseTag = "R4";
    loadValue(32'h0000_ACE1);
    tick(65534);
    chk("R4 16 no early pulse", {31'b0, pd16}, 32'h0);
    tick(1);
    chk("R4 16 period", {31'b0, pd16}, 32'h1);
    chk("R4 16 state", {16'b0, s16}, 32'hACE1);
    chk("R4 8 period also", {31'b0, pd8}, 32'h1);
    chk("R10 not lock 8x", {31'b0, (s8 == 8'h00)}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule